// File: doc/BRIEF.md
# Two-bank file register store with direct and pointer addressing

This block holds the 256-byte data memory of a small 8-bit controller core and works out which byte each file-register access reaches. The memory is split into two banks of 128 bytes. An instruction supplies a 7-bit file field. For a direct access, the bank is chosen by the low bank bit in a status byte that the block holds.

Offset 0 of either bank is a data port that goes through a pointer instead. When the field is zero, the full 8-bit pointer is the address, and pointer bit 7 picks the bank. The status bank bits play no part in this case.

The pointer sits at offset 4 and the status byte at offset 3. Both are visible from either bank, so software can always reach them. A separate instruction bit says whether a result is written back to the file. The core's ALU, its decode logic and any peripheral behind a mapped location are outside this block.

Top module: `bank_regfile`

## Requirements
- R1: A direct access (field non-zero) reaches address {status bit 5, field}, so the same field in bank 0 and in bank 1 names two distinct bytes.
- R2: A field of 0 is an indirect access. Its address is the whole 8-bit pointer, and pointer bit 7 selects the bank.
- R3: Status bits 5 and 6 have no effect on an indirect access. Pointer 0x81 always reaches byte 0x81, and pointer 0x01 always reaches byte 0x01.
- R4: Status bit 6 (upper bank) and bit 7 (indirect page) can be stored and read back, but they never change any address.
- R5: The pointer is a full 8-bit register at offset 4 of both banks, and the status byte is at offset 3 of both banks. Writing 0x80 to the pointer reads back 0x80.
- R6: If an access resolves to offset 0 of either bank (through a pointer whose low 7 bits are zero), it reads 0x00 and a write to it changes nothing.
- R7: A file write happens on the rising clock edge only when wr_en is 1 and dst_file is 1. When dst_file is 0, nothing in the file changes.
- R8: Reads are combinational from the resolved address. While rd_en is 0, rd_data is 0x00.
- R9: A synchronous reset clears the pointer and the status byte to 0x00, and stat_bits shows status bits {7,6,5}. Memory bytes are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fld_addr | input | 7 | File field from the instruction; 0 selects the pointer port |
| dst_file | input | 1 | 1 = result goes back to the file, 0 = to the working register |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Data to write |
| rd_data | output | 8 | Data read from the resolved location |
| stat_bits | output | 3 | Status {indirect page, upper bank, lower bank} |

## Verification
The bench builds the block with its default values: an 8-bit data path, a 7-bit field, the pointer at offset 4 and the status byte at offset 3. These defaults make all 256 bytes reachable. They also let the bench put every possible value in the ignored status bits while walking pointers that cross the bank boundary, such as 0x20 against 0xA0. With a full byte-wide pointer, the bench can also aim the pointer at the port itself and at the mirrored pointer and status locations.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;
    typedef enum logic [1:0] {
        TGT_MEM  = 2'd0,
        TGT_PTR  = 2'd1,
        TGT_STAT = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;
endpackage

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
    import bank_rf_pkg::*;
#(
    parameter int FLD_W    = 7,
    parameter int PTR_OFF  = 4,
    parameter int STAT_OFF = 3
) (
    input  logic [FLD_W-1:0] fld,
    input  logic [FLD_W:0]   ptr,
    input  logic             bank_lo,
    output logic [FLD_W:0]   eff,
    output tgt_e             tgt
);
    localparam logic [FLD_W-1:0] PTR_L  = FLD_W'(PTR_OFF);
    localparam logic [FLD_W-1:0] STAT_L = FLD_W'(STAT_OFF);

    always_comb begin
        // field zero means go through the pointer; bank bits unused then
        if (fld == '0) eff = ptr;
        else           eff = {bank_lo, fld};

        if (eff[FLD_W-1:0] == '0)          tgt = TGT_NONE;
        else if (eff[FLD_W-1:0] == PTR_L)  tgt = TGT_PTR;
        else if (eff[FLD_W-1:0] == STAT_L) tgt = TGT_STAT;
        else                               tgt = TGT_MEM;
    end
endmodule

// File: rtl/bank_mem.sv
module bank_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
    import bank_rf_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int FLD_W    = 7,
    parameter int PTR_OFF  = 4,
    parameter int STAT_OFF = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLD_W-1:0]  fld_addr,
    input  logic              dst_file,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        stat_bits
);
    localparam int ADDR_W      = FLD_W + 1;
    localparam int BANK_LO_BIT = DATA_W - 3;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic [DATA_W-1:0] stat;
    } regs_t;

    regs_t             regs_d, regs_q;
    logic [ADDR_W-1:0] eff;
    tgt_e              tgt;
    logic              file_we;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rd;

    bank_addr_gen #(
        .FLD_W   (FLD_W),
        .PTR_OFF (PTR_OFF),
        .STAT_OFF(STAT_OFF)
    ) u_agen (
        .fld    (fld_addr),
        .ptr    (regs_q.ptr),
        .bank_lo(regs_q.stat[BANK_LO_BIT]),
        .eff    (eff),
        .tgt    (tgt)
    );

    bank_mem #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_mem (
        .clk  (clk),
        .we   (mem_we),
        .addr (eff),
        .wdata(wr_data),
        .rdata(mem_rd)
    );

    always_comb begin
        regs_d  = regs_q;
        file_we = wr_en && dst_file;
        mem_we  = file_we && (tgt == TGT_MEM) && !rst;
        if (file_we) begin
            if (tgt == TGT_PTR)  regs_d.ptr  = ADDR_W'(wr_data);
            if (tgt == TGT_STAT) regs_d.stat = wr_data;
        end
        if (rst) regs_d = '0;

        rd_data = '0;
        if (rd_en) begin
            case (tgt)
                TGT_MEM:  rd_data = mem_rd;
                TGT_PTR:  rd_data = DATA_W'(regs_q.ptr);
                TGT_STAT: rd_data = regs_q.stat;
                default:  rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign stat_bits = regs_q.stat[DATA_W-1 -: 3];

    // ---------------- assertions ----------------
    logic rst_d1_q;
    always_ff @(posedge clk) begin
        rst_d1_q <= rst;
        if (rst_d1_q == 1'b1) begin
            assert_reset_clear_R9: assert (regs_q.ptr == '0 && regs_q.stat == '0)
                else $error("pointer or status not cleared by reset");
        end
    end

    assert_ind_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (fld_addr == '0) |-> (eff == regs_q.ptr));

    assert_dir_addr_R4: assert property (@(posedge clk) disable iff (rst)
        (fld_addr != '0) |-> (eff[ADDR_W-1] == stat_bits[0]));

    assert_no_dst_R7: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && dst_file) |=> ($stable(regs_q.ptr) && $stable(regs_q.stat)));

    assert_port_write_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dst_file && tgt == TGT_NONE) |=>
        ($stable(regs_q.ptr) && $stable(regs_q.stat)));

    assert_idle_read_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0));
endmodule

// File: tb/sim_bank_regfile.sv
module sim_bank_regfile;
    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] fld_addr = '0;
    logic       dst_file = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [2:0] stat_bits;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb_q[$];
    event  smp;

    logic [7:0] m_mem [256];
    logic [7:0] m_ptr;
    logic [7:0] m_stat;

    always #5 clk = ~clk;

    bank_regfile u0 (
        .clk      (clk),
        .rst      (rst),
        .fld_addr (fld_addr),
        .dst_file (dst_file),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .stat_bits(stat_bits)
    );

    function automatic logic [7:0] m_eff(input logic [6:0] f);
        if (f == 7'd0) return m_ptr;
        return {m_stat[5], f};
    endfunction

    function automatic logic [7:0] m_read(input logic [6:0] f);
        logic [7:0] a = m_eff(f);
        if (a[6:0] == 7'd0) return 8'h00;
        if (a[6:0] == 7'd4) return m_ptr;
        if (a[6:0] == 7'd3) return m_stat;
        return m_mem[a];
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] f, input logic d, input logic [7:0] v);
        logic [7:0] a;
        @(negedge clk);
        fld_addr = f; dst_file = d; wr_data = v; wr_en = 1'b1; rd_en = 1'b0;
        a = m_eff(f);
        @(posedge clk);
        if (d) begin
            if (a[6:0] == 7'd4)      m_ptr = v;
            else if (a[6:0] == 7'd3) m_stat = v;
            else if (a[6:0] != 7'd0) m_mem[a] = v;
        end
        @(negedge clk);
        wr_en = 1'b0; dst_file = 1'b0;
    endtask

    task automatic do_read(input logic [6:0] f, input string tag);
        item_t it;
        @(negedge clk);
        fld_addr = f; rd_en = 1'b1; wr_en = 1'b0;
        it.exp = m_read(f);
        it.tag = tag;
        sb_q.push_back(it);
        #2;
        ->smp;
        #1;
        rd_en = 1'b0;
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(smp);
            if (sb_q.size() == 0) begin
                check(8'hxx, 8'h00, "scoreboard empty");
            end else begin
                it = sb_q.pop_front();
                check(rd_data, it.exp, it.tag);
            end
        end
    end

    initial begin : watchdog
        #1500us;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        m_ptr = 8'h00; m_stat = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check({5'd0, stat_bits}, 8'h00, "R9 stat_bits after reset");
        do_read(7'd4, "R9 pointer after reset");
        do_read(7'd3, "R9 status after reset");

        // R1 direct bank selection
        do_write(7'h20, 1'b1, 8'hA5);
        do_write(7'd3, 1'b1, 8'h20);
        #1 check({5'd0, stat_bits}, 8'h01, "R9 stat_bits bank0 set");
        do_write(7'h20, 1'b1, 8'h5A);
        do_read(7'h20, "R1 bank1 byte 0xA0");
        do_write(7'd3, 1'b1, 8'h00);
        do_read(7'h20, "R1 bank0 byte 0x20");

        // R5 pointer full byte, mirrored
        do_write(7'd4, 1'b1, 8'h80);
        do_read(7'd4, "R5 pointer readback 0x80 bank0");
        do_write(7'd3, 1'b1, 8'h20);
        do_read(7'd4, "R5 pointer seen from bank1");
        do_read(7'd3, "R5 status seen from bank1");

        // R2 / R3 indirect ignores bank bits
        do_write(7'd4, 1'b1, 8'hA0);
        do_read(7'd0, "R2 pointer 0xA0 with bank1");
        do_write(7'd3, 1'b1, 8'h00);
        do_read(7'd0, "R3 pointer 0xA0 with bank0");
        do_write(7'd4, 1'b1, 8'h20);
        do_write(7'd3, 1'b1, 8'h60);
        do_read(7'd0, "R3 pointer 0x20 with bank bits set");
        do_write(7'd4, 1'b1, 8'h30);
        do_write(7'd0, 1'b1, 8'h3C);
        do_write(7'd3, 1'b1, 8'h00);
        do_read(7'h30, "R2 indirect write reached 0x30");
        do_write(7'd3, 1'b1, 8'h20);
        do_read(7'h30, "R3 bank1 0xB0 untouched");

        // R4 upper bank and page bits stored, ignored
        do_write(7'd3, 1'b1, 8'hC0);
        #1 check({5'd0, stat_bits}, 8'h06, "R4 stat_bits upper bits");
        do_read(7'd3, "R4 status readback 0xC0");
        do_read(7'h20, "R4 direct stays in bank0");
        do_write(7'd4, 1'b1, 8'h20);
        do_read(7'd0, "R4 indirect ignores page bit");

        // R6 pointer aimed at the port
        do_write(7'd4, 1'b1, 8'h80);
        do_read(7'd0, "R6 port via pointer 0x80 reads zero");
        do_write(7'd0, 1'b1, 8'h77);
        do_read(7'd4, "R6 pointer kept after port write");
        do_read(7'd3, "R6 status kept after port write");
        do_read(7'd0, "R6 port still zero");

        // indirect reaching pointer and status
        do_write(7'd4, 1'b1, 8'h84);
        do_read(7'd0, "R5 indirect reads pointer");
        do_write(7'd4, 1'b1, 8'h83);
        do_write(7'd0, 1'b1, 8'h20);
        #1 check({5'd0, stat_bits}, 8'h01, "R5 status written through pointer");

        // R7 destination bit
        do_write(7'h20, 1'b0, 8'hEE);
        do_read(7'h20, "R7 dst=0 leaves bank1 byte");
        do_write(7'd4, 1'b0, 8'h11);
        do_read(7'd4, "R7 dst=0 leaves pointer");

        // R8 idle read
        @(negedge clk);
        fld_addr = 7'd4; rd_en = 1'b0;
        #2 check(rd_data, 8'h00, "R8 rd_data zero when idle");

        // R9 reset again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_ptr = 8'h00; m_stat = 8'h00;
        do_read(7'd4, "R9 pointer cleared");
        do_read(7'h20, "R9 memory kept over reset");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule